// File: doc/BRIEF.md
# Two-Wire Control Bus Router

This block listens to an upstream two-wire control bus (SCL/SDA) and decides which downstream target currently owns it: a boot PROM port, one of two display-data-channel ports (one per video output), or the block's own register file. Coming out of reset the bus is handed to the PROM port and the block only snoops the traffic. When it sees a transaction to its own device address, it takes the bus for its internal registers and acknowledges the bytes itself.

While the registers own the bus, software writes a target code into a route command register. The new target takes effect at the STOP that closes the transaction, so no transaction is split across two targets. A display-data-channel route carries one transaction and then hands the bus back to the registers, at the first STOP that follows a START. The outputs are one enable per target, the current route code, and an acknowledge request that tells the pad logic to pull SDA low.

Both bus lines are sampled by a faster system clock through two-flop synchronizers. START and STOP are then found from SDA edges while SCL is high.

Top module: `ctl_bus_router`

## Requirements
- R1: In the first cycles after reset the route is 0 (PROM), only the PROM enable is high, and the acknowledge request is low.
- R2: The 7-bit own address is 0111 00 followed by the inverse of `addr_sel_i`: 0x38 (byte 70h) when the strap is high and 0x39 (byte 72h) when it is low. A matching address byte seen while routed to PROM moves the route to 1 (registers) before the STOP. The only exit from route 0 is to route 1.
- R3: In route 0, a transaction to any other address leaves the route at 0 and is never acknowledged.
- R4: In route 1, the first data byte of a write is a register index. A data byte written at index 0x0E loads a pending target from its bits [1:0], with codes 0 PROM, 1 registers, 2 DDC port A and 3 DDC port B. The route takes the pending code at the STOP and stays unchanged before it.
- R5: In route 2 or 3, the route returns to 1 at the first STOP that follows a START. The only exit from routes 2 and 3 is to route 1.
- R6: Exactly one of the four enables is high, and it is the one whose code matches `route_o` (bit order PROM, registers, DDC A, DDC B).
- R7: The acknowledge request is high during the ninth SCL pulse of a matching address byte and of every data byte of a write to the own address. It is never high in route 2 or 3, including for a matching address.
- R8: A write to an index other than 0x0E leaves the route at 1 after the STOP.
- R9: The register index advances by one after each data byte, so a second data byte that follows index 0x0D lands on the route command register.
- R10: A read to the own address is acknowledged on its address byte only, leaves the route at 1, and changes nothing at its STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Upstream bus clock as seen on the wire |
| sda_i | input | 1 | Upstream bus data as seen on the wire |
| addr_sel_i | input | 1 | Address-select strap; its inverse forms address bit 0 |
| route_o | output | 2 | Current route code |
| en_prom_o | output | 1 | PROM port enable |
| en_reg_o | output | 1 | Internal register target enable |
| en_ddca_o | output | 1 | DDC port A enable |
| en_ddcb_o | output | 1 | DDC port B enable |
| ack_o | output | 1 | Request to pull SDA low for an acknowledge |

## Verification
The assertions take for granted that SCL and SDA each stay stable for several system clocks. This lets the synchronizers deliver every edge and keeps SDA from changing in the same sample as an SCL edge, except where it forms a START or STOP. The strap is assumed to change only under reset. The bench drives the bus through tasks that hold every phase for eight clocks and change SDA only while SCL is low, except for deliberate START and STOP. Random transactions choose between the own address and other addresses, reads and writes, and command or ordinary indices. A bench model predicts the acknowledge for each byte and the route after each STOP.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int N_TGT  = 4;

  typedef enum logic [1:0] {
    RT_PROM = 2'd0,
    RT_REG  = 2'd1,
    RT_DDCA = 2'd2,
    RT_DDCB = 2'd3
  } route_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/cbr_sync_edge.sv
module cbr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/cbr_byte_snoop.sv
module cbr_byte_snoop
  import cbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              listen,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              hit_p,
  output logic              data_p,
  output logic              first_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ack_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACKB = CNT_W'(BYTE_W);

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] nxt;
  logic              ack_pend, first;

  assign nxt = {shreg[BYTE_W-2:0], sda};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      ack_pend <= 1'b0;
      first    <= 1'b0;
      hit_p    <= 1'b0;
      data_p   <= 1'b0;
      first_o  <= 1'b0;
      byte_o   <= '0;
      ack_o    <= 1'b0;
    end else begin
      hit_p  <= 1'b0;
      data_p <= 1'b0;
      if (start_p) begin
        phase    <= PH_ADDR;
        cnt      <= '0;
        ack_o    <= 1'b0;
        ack_pend <= 1'b0;
        first    <= 1'b1;
      end else if (stop_p) begin
        phase    <= PH_IDLE;
        ack_o    <= 1'b0;
        ack_pend <= 1'b0;
      end else begin
        if (scl_rise && phase != PH_IDLE) begin
          if (cnt == ACKB) begin
            cnt <= '0;
          end else begin
            shreg <= nxt;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST) begin
              case (phase)
                PH_ADDR: begin
                  if (listen && nxt[BYTE_W-1:1] == own_addr) begin
                    hit_p    <= 1'b1;
                    ack_pend <= 1'b1;
                    phase    <= nxt[0] ? PH_SKIP : PH_DATA;
                  end else begin
                    ack_pend <= 1'b0;
                    phase    <= PH_SKIP;
                  end
                end
                PH_DATA: begin
                  data_p   <= 1'b1;
                  byte_o   <= nxt;
                  first_o  <= first;
                  first    <= 1'b0;
                  ack_pend <= 1'b1;
                end
                default: ack_pend <= 1'b0;
              endcase
            end
          end
        end
        if (scl_fall) begin
          ack_o <= (cnt == ACKB) ? ack_pend : 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cbr_route_ctl.sv
module cbr_route_ctl
  import cbr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CMD_INDEX = 8'h0E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_p,
  input  logic              data_p,
  input  logic              first_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              start_p,
  input  logic              stop_p,
  output route_t            route_o,
  output logic [N_TGT-1:0]  en_o,
  output logic              listen_o
);
  route_t            route_q, route_d, pend_q;
  logic              pend_v, seen_start;
  logic [BYTE_W-1:0] ptr_q;

  always_comb begin
    route_d = route_q;
    case (route_q)
      RT_PROM: if (hit_p) route_d = RT_REG;
      RT_REG:  if (stop_p && pend_v) route_d = pend_q;
      default: if (stop_p && seen_start) route_d = RT_REG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q    <= RT_PROM;
      en_o       <= N_TGT'(1);
      pend_q     <= RT_REG;
      pend_v     <= 1'b0;
      seen_start <= 1'b0;
      ptr_q      <= '0;
    end else begin
      route_q <= route_d;
      en_o    <= N_TGT'(1) << route_d;
      if (route_d != route_q)
        seen_start <= 1'b0;
      else if (start_p && route_q[1])
        seen_start <= 1'b1;
      if (route_q == RT_REG && stop_p)
        pend_v <= 1'b0;
      else if (data_p) begin
        if (first_i) begin
          ptr_q <= byte_i;
        end else begin
          if (ptr_q == CMD_INDEX) begin
            pend_q <= route_t'(byte_i[1:0]);
            pend_v <= 1'b1;
          end
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end

  assign route_o  = route_q;
  assign listen_o = ~route_q[1];
endmodule

// File: rtl/ctl_bus_router.sv
module ctl_bus_router
  import cbr_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] CMD_INDEX   = 8'h0E
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel_i,
  output logic [1:0] route_o,
  output logic       en_prom_o,
  output logic       en_reg_o,
  output logic       en_ddca_o,
  output logic       en_ddcb_o,
  output logic       ack_o
);
  logic              sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic              hit_p, data_p, first_b, listen;
  logic [BYTE_W-1:0] data_b;
  logic [N_TGT-1:0]  en;
  logic [ADDR_W-1:0] own_addr;
  route_t            route;

  assign own_addr = {6'b011100, ~addr_sel_i};

  cbr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_p), .stop_o(stop_p)
  );

  cbr_byte_snoop u_snoop (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda(sda_s), .start_p(start_p), .stop_p(stop_p), .listen(listen),
    .own_addr(own_addr), .hit_p(hit_p), .data_p(data_p),
    .first_o(first_b), .byte_o(data_b), .ack_o(ack_o)
  );

  cbr_route_ctl #(.CMD_INDEX(CMD_INDEX)) u_route (
    .clk(clk), .rst(rst), .hit_p(hit_p), .data_p(data_p),
    .first_i(first_b), .byte_i(data_b), .start_p(start_p),
    .stop_p(stop_p), .route_o(route), .en_o(en), .listen_o(listen)
  );

  assign route_o   = route;
  assign en_prom_o = en[0];
  assign en_reg_o  = en[1];
  assign en_ddca_o = en[2];
  assign en_ddcb_o = en[3];
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] route,
  input logic [3:0] en,
  input logic       ack
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (route == 2'd0 && en == 4'b0001 && !ack));

  assert_prom_exit_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(route) == 2'd0 && route != 2'd0) |-> route == 2'd1);

  assert_ddc_exit_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(route) >= 2'd2 && route != $past(route)) |-> route == 2'd1);

  assert_enable_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(en) == 1 && en[route]);

  assert_no_ack_ddc_R7: assert property (@(posedge clk) disable iff (rst)
    ack |-> !route[1]);
endmodule

bind ctl_bus_router cbr_checker u_chk (
  .clk(clk), .rst(rst), .route(route_o),
  .en({en_ddcb_o, en_ddca_o, en_reg_o, en_prom_o}), .ack(ack_o)
);

// File: tb/tb_ctl_bus_router.sv
module tb_ctl_bus_router;
  localparam int HALF = 8;
  localparam logic [7:0] CMD = 8'h0E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda = 1'b1, strap = 1'b1;
  logic [1:0] route;
  logic e_prom, e_reg, e_da, e_db, ack;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int exp_route, pend, ptr;
  bit pv, seen;
  logic [7:0] dbuf [4];

  always #5 clk = ~clk;

  ctl_bus_router dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .addr_sel_i(strap),
    .route_o(route), .en_prom_o(e_prom), .en_reg_o(e_reg),
    .en_ddca_o(e_da), .en_ddcb_o(e_db), .ack_o(ack)
  );

  function automatic logic [6:0] own(input logic s);
    return {6'b011100, ~s};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_route(input string tag);
    check({tag, " route"}, route, exp_route);
    check("R6 enables", {e_db, e_da, e_reg, e_prom}, 1 << exp_route);
  endtask

  task automatic b_start;
    sda = 1; gap(HALF); scl = 1; gap(HALF); sda = 0; gap(HALF); scl = 0; gap(HALF);
  endtask

  task automatic b_stop;
    sda = 0; gap(HALF); scl = 1; gap(HALF); sda = 1; gap(HALF + 4);
  endtask

  task automatic b_byte(input logic [7:0] v, input bit exp_ack, input string tag);
    for (int i = 7; i >= 0; i--) begin
      sda = v[i]; gap(HALF); scl = 1; gap(HALF); scl = 0; gap(HALF);
    end
    sda = 1; gap(HALF); scl = 1; gap(HALF / 2);
    check(tag, ack, exp_ack);
    gap(HALF / 2); scl = 0; gap(HALF);
  endtask

  // One transaction with nd data bytes from dbuf; model updated alongside
  task automatic txn(input logic [6:0] a, input bit rw, input int nd);
    bit hit;
    b_start;
    if (exp_route >= 2) seen = 1;
    hit = (exp_route < 2) && (a == own(strap));
    b_byte({a, rw}, hit, hit ? "R2/R7 addr ack" : "R3/R7 no addr ack");
    if (hit && exp_route == 0) exp_route = 1;
    check_route("R2 after address");
    for (int i = 0; i < nd; i++) begin
      b_byte(dbuf[i], hit && !rw, "R7 data ack");
      if (hit && !rw) begin
        if (i == 0) ptr = dbuf[i];
        else begin
          if (ptr[7:0] == CMD) begin pend = dbuf[i][1:0]; pv = 1; end
          ptr = (ptr + 1) & 8'hFF;
        end
      end
    end
    check_route("R4 before stop");
    b_stop;
    if (exp_route == 1 && pv) begin exp_route = pend; pv = 0; end
    else if (exp_route >= 2 && seen) begin exp_route = 1; seen = 0; end
    check_route("R4/R5 after stop");
  endtask

  task automatic do_reset(input logic s);
    rst = 1; strap = s; scl = 1; sda = 1;
    gap(5); rst = 0; gap(4);
    exp_route = 0; pv = 0; seen = 0; ptr = 0; pend = 1;
    check_route("R1 reset");
    check("R1 ack at reset", ack, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset(1'b1);
    // R3: foreign address while in PROM route
    dbuf[0] = 8'h0E; dbuf[1] = 8'h02;
    txn(7'h50, 0, 2);
    // R2 own address 0x38 with strap high, R4 command to DDC A
    txn(7'h38, 0, 2);
    check("R4 route DDC A", route, 2);
    // R5/R7: own address ignored in DDC route, back to registers at stop
    dbuf[0] = 8'h0E; dbuf[1] = 8'h03;
    txn(7'h38, 0, 2);
    check("R5 back to registers", route, 1);
    // R8: other index
    dbuf[0] = 8'h05; dbuf[1] = 8'h03;
    txn(7'h38, 0, 2);
    check("R8 route stays 1", route, 1);
    // R9: index 0x0D then two bytes, second lands on command
    dbuf[0] = 8'h0D; dbuf[1] = 8'h00; dbuf[2] = 8'h03;
    txn(7'h38, 0, 3);
    check("R9 route DDC B", route, 3);
    // R5: bare START/STOP in DDC B
    b_start; seen = 1; b_stop; exp_route = 1; seen = 0;
    check_route("R5 bare start stop");
    // R10: read to own address
    txn(7'h38, 1, 0);
    check("R10 route after read", route, 1);
    // R4 code 1 keeps registers, code 0 returns to PROM
    dbuf[0] = 8'h0E; dbuf[1] = 8'h01;
    txn(7'h38, 0, 2);
    dbuf[1] = 8'hFC;
    txn(7'h38, 0, 2);
    check("R4 route PROM", route, 0);
    // Random phase
    for (int k = 0; k < 50; k++) begin
      logic [6:0] a;
      bit rw;
      int nd;
      if ($urandom_range(1, 0) == 1) a = own(strap);
      else begin
        a = 7'($urandom_range(127, 0));
        if (a == own(strap)) a = 7'h50;
      end
      rw = ($urandom_range(4, 0) == 0);
      nd = rw ? 0 : int'($urandom_range(3, 0));
      case ($urandom_range(3, 0))
        0, 1: dbuf[0] = CMD;
        2: dbuf[0] = 8'h0D;
        default: dbuf[0] = 8'($urandom_range(255, 0));
      endcase
      for (int j = 1; j < 4; j++) dbuf[j] = 8'($urandom_range(255, 0));
      txn(a, rw, nd);
    end
    // R2: strap low gives 0x39; 0x38 must be ignored
    do_reset(1'b0);
    dbuf[0] = 8'h0E; dbuf[1] = 8'h03;
    txn(7'h38, 0, 2);
    check("R2 strap low 0x38 ignored", route, 0);
    txn(7'h39, 0, 2);
    check("R2 strap low 0x39 to DDC B", route, 3);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule